// File: doc/BRIEF.md
# Exclusive Access Reservation Unit

This block sits in the memory stage of a 32-bit core and gives word accesses load-reserved / store-conditional behaviour. It decodes each load or store and reports its transfer size and whether it asks for byte-reversed order. It also spots the exclusive variant, which only the register-operand format can request. An exclusive load records the word-aligned address it reads. An exclusive store writes memory only when its own word-aligned address equals that recorded address.

Success or failure goes back to software through the carry flag: 0 means the store happened and 1 means it was dropped. Exclusive accesses clear the two low address bits instead of faulting on misalignment. The memory address, the store-enable qualifier and the carry update are all combinational from the access strobe. The stored reservation changes on the clock edge that follows an exclusive load.

Top module: `lrsc_resv_unit`

## Requirements
- R1: `size_bytes` equals 1 shifted left by `size_code`: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R2: When `imm_fmt` is 0, `instr` bit 9 set makes `rev_order` 1 and `instr` bit 10 set marks the access exclusive. When `imm_fmt` is 1, `rev_order` is 0 and the access is never exclusive, whatever those bits hold.
- R3: For an exclusive access, `mem_addr` is `eff_addr` with bits 1:0 forced to 0. For any other access, `mem_addr` equals `eff_addr` unchanged.
- R4: A strobed exclusive load drives `carry_we`=1, `carry_val`=0 and `mem_we`=0, and from the next clock edge the reservation holds its aligned address.
- R5: A strobed exclusive store drives `carry_we`=1. If its aligned address equals the reservation, it drives `carry_val`=0 and `mem_we`=1. Otherwise it drives `carry_val`=1 and `mem_we`=0.
- R6: An exclusive store leaves the reservation unchanged, so a second exclusive store to the same word also succeeds.
- R7: Non-exclusive accesses drive `carry_we`=0 and leave the reservation unchanged. A strobed non-exclusive store drives `mem_we`=1 and a load drives `mem_we`=0.
- R8: Reset sets the reservation to all ones, so an exclusive store issued before any exclusive load fails.
- R9: With `acc_valid` low, `mem_we` and `carry_we` are 0 and the reservation is unchanged, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Load/store strobe for this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| imm_fmt | input | 1 | 1 = immediate-operand format |
| instr | input | 32 | Instruction word |
| size_code | input | 2 | Opcode size field |
| eff_addr | input | 32 | Computed effective address |
| mem_addr | output | 32 | Address presented to memory |
| mem_we | output | 1 | Store-enable qualifier |
| size_bytes | output | 4 | Access size in bytes |
| rev_order | output | 1 | Byte-reversed access requested |
| carry_we | output | 1 | Carry flag update enable |
| carry_val | output | 1 | New carry value (0 = exclusive success) |

## Verification
Exclusive stores are tried in four situations. They follow an exclusive load to the same word through a different byte offset. They go to a neighbouring word. They come straight after reset. They repeat with no new load. Together these separate a real address match from a plain ignore-the-low-bits pass and from a reservation that a store wrongly clears. Plain loads and stores, unstrobed cycles and immediate-format words with bits 9 and 10 set are placed between exclusive pairs. A following exclusive store then shows through `carry_val` whether the reservation stayed intact. Unaligned addresses on both exclusive and plain accesses show that alignment is applied only to the exclusive variant.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    // Decoded view of one memory-stage access.
    typedef struct packed {
        logic excl;   // exclusive variant
        logic rev;    // byte-reversed order
        logic ld;     // strobed load
        logic st;     // strobed store
    } lrsc_acc_t;

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
    import lrsc_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter int REV_BIT  = 9,
    parameter int EXCL_BIT = 10,
    parameter int SIZE_W   = 2,
    parameter int BYTES_W  = 4
) (
    input  logic               acc_valid,
    input  logic               acc_store,
    input  logic               imm_fmt,
    input  logic [INSTR_W-1:0] instr,
    input  logic [SIZE_W-1:0]  size_code,
    output lrsc_acc_t          acc,
    output logic [BYTES_W-1:0] size_bytes
);

    logic unused_instr;
    assign unused_instr = ^instr;

    always_comb begin
        acc        = '0;
        acc.rev    = !imm_fmt && instr[REV_BIT];
        acc.excl   = !imm_fmt && instr[EXCL_BIT];
        acc.ld     = acc_valid && !acc_store;
        acc.st     = acc_valid && acc_store;
        size_bytes = BYTES_W'(1) << size_code;
    end

endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    output logic [ADDR_W-1:0] resv_addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } resv_state_t;

    // All ones has its low bits set, so no aligned address can equal it.
    localparam resv_state_t RESV_RESET = '{addr: '1};

    resv_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_en) begin
            state_d.addr = set_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESV_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign resv_addr = state_q.addr;

endmodule

// File: rtl/lrsc_store_qual.sv
module lrsc_store_qual
    import lrsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  lrsc_acc_t         acc,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [ADDR_W-1:0] resv_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              carry_we,
    output logic              carry_val,
    output logic              set_en,
    output logic [ADDR_W-1:0] set_addr
);

    localparam logic [ADDR_W-1:0] LOW_MASK   = ADDR_W'((64'd1 << ALIGN_BITS) - 64'd1);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~LOW_MASK;

    logic [ADDR_W-1:0] aligned;
    logic              hit;

    always_comb begin
        aligned   = eff_addr & ALIGN_MASK;
        hit       = (aligned == resv_addr);
        mem_addr  = acc.excl ? aligned : eff_addr;
        mem_we    = 1'b0;
        carry_we  = 1'b0;
        carry_val = 1'b0;
        set_en    = 1'b0;
        set_addr  = aligned;
        if (acc.ld) begin
            if (acc.excl) begin
                carry_we = 1'b1;
                set_en   = 1'b1;
            end
        end else if (acc.st) begin
            if (acc.excl) begin
                carry_we  = 1'b1;
                carry_val = !hit;
                mem_we    = hit;
            end else begin
                mem_we = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lrsc_resv_unit.sv
module lrsc_resv_unit
    import lrsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSTR_W    = 32,
    parameter int REV_BIT    = 9,
    parameter int EXCL_BIT   = 10,
    parameter int SIZE_W     = 2,
    parameter int ALIGN_BITS = 2,
    localparam int BYTES_W   = (1 << SIZE_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_store,
    input  logic               imm_fmt,
    input  logic [INSTR_W-1:0] instr,
    input  logic [SIZE_W-1:0]  size_code,
    input  logic [ADDR_W-1:0]  eff_addr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_we,
    output logic [BYTES_W-1:0] size_bytes,
    output logic               rev_order,
    output logic               carry_we,
    output logic               carry_val
);

    lrsc_acc_t         acc;
    logic              set_en;
    logic [ADDR_W-1:0] set_addr;
    logic [ADDR_W-1:0] resv_q;

    lrsc_decode #(
        .INSTR_W (INSTR_W),
        .REV_BIT (REV_BIT),
        .EXCL_BIT(EXCL_BIT),
        .SIZE_W  (SIZE_W),
        .BYTES_W (BYTES_W)
    ) u_decode (
        .acc_valid (acc_valid),
        .acc_store (acc_store),
        .imm_fmt   (imm_fmt),
        .instr     (instr),
        .size_code (size_code),
        .acc       (acc),
        .size_bytes(size_bytes)
    );

    lrsc_store_qual #(
        .ADDR_W    (ADDR_W),
        .ALIGN_BITS(ALIGN_BITS)
    ) u_qual (
        .acc      (acc),
        .eff_addr (eff_addr),
        .resv_addr(resv_q),
        .mem_addr (mem_addr),
        .mem_we   (mem_we),
        .carry_we (carry_we),
        .carry_val(carry_val),
        .set_en   (set_en),
        .set_addr (set_addr)
    );

    lrsc_resv_reg #(
        .ADDR_W(ADDR_W)
    ) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .set_addr (set_addr),
        .resv_addr(resv_q)
    );

    assign rev_order = acc.rev;

endmodule

// File: rtl/lrsc_resv_chk.sv
module lrsc_resv_chk #(
    parameter int ADDR_W   = 32,
    parameter int INSTR_W  = 32,
    parameter int EXCL_BIT = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_store,
    input logic               imm_fmt,
    input logic [INSTR_W-1:0] instr,
    input logic [ADDR_W-1:0]  eff_addr,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               mem_we,
    input logic               carry_we,
    input logic               carry_val,
    input logic [ADDR_W-1:0]  resv_q
);

    logic unused_chk;
    assign unused_chk = ^instr;

    logic excl_req;
    assign excl_req = !imm_fmt && instr[EXCL_BIT];

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!mem_we && !carry_we)); // R9

    AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_store) |-> !mem_we); // R7

    AST_EXCL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && excl_req) |-> (mem_addr[1:0] == 2'b00 && mem_addr[ADDR_W-1:2] == eff_addr[ADDR_W-1:2])); // R3

    AST_PLAIN_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !excl_req) |-> !carry_we); // R7

    AST_STORE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_store && excl_req) |-> (carry_we && (mem_we == !carry_val))); // R5

    AST_RESV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_store && excl_req) |=> (resv_q == {$past(eff_addr[ADDR_W-1:2]), 2'b00})); // R4

    AST_RESV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_store && excl_req) |=> $stable(resv_q)); // R6

endmodule

bind lrsc_resv_unit lrsc_resv_chk #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W),
    .EXCL_BIT(EXCL_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_store(acc_store),
    .imm_fmt  (imm_fmt),
    .instr    (instr),
    .eff_addr (eff_addr),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .carry_we (carry_we),
    .carry_val(carry_val),
    .resv_q   (resv_q)
);

// File: tb/lrsc_resv_unit_tb.sv
module lrsc_resv_unit_tb;

    localparam int T = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_store = 1'b0;
    logic        imm_fmt = 1'b0;
    logic [31:0] instr = '0;
    logic [1:0]  size_code = '0;
    logic [31:0] eff_addr = '0;
    logic [31:0] mem_addr;
    logic        mem_we;
    logic [3:0]  size_bytes;
    logic        rev_order;
    logic        carry_we;
    logic        carry_val;

    always #(T/2) clk = ~clk;

    lrsc_resv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_store(acc_store),
        .imm_fmt(imm_fmt), .instr(instr), .size_code(size_code), .eff_addr(eff_addr),
        .mem_addr(mem_addr), .mem_we(mem_we), .size_bytes(size_bytes),
        .rev_order(rev_order), .carry_we(carry_we), .carry_val(carry_val)
    );

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [3:0]  bytes;
        logic        rev;
        logic        cwe;
        logic        cval;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] model_resv = 32'hFFFF_FFFF;

    localparam logic [31:0] EXB = 32'h0000_0400; // instr bit 10
    localparam logic [31:0] RVB = 32'h0000_0200; // instr bit 9

    task automatic drv(input logic v, input logic st, input logic imm,
                       input logic [31:0] iw, input logic [1:0] sc,
                       input logic [31:0] a, input string tag);
        exp_t e;
        logic ex;
        @(negedge clk);
        acc_valid = v; acc_store = st; imm_fmt = imm;
        instr = iw; size_code = sc; eff_addr = a;
        ex      = !imm && iw[10];
        e.tag   = tag;
        e.bytes = 4'd1 << sc;
        e.rev   = !imm && iw[9];
        e.addr  = ex ? {a[31:2], 2'b00} : a;
        e.we    = 1'b0;
        e.cwe   = 1'b0;
        e.cval  = 1'b0;
        if (v && !st && ex) begin
            e.cwe = 1'b1;
        end else if (v && st && ex) begin
            e.cwe  = 1'b1;
            e.cval = ({a[31:2], 2'b00} != model_resv);
            e.we   = !e.cval;
        end else if (v && st) begin
            e.we = 1'b1;
        end
        sb_q.push_back(e);
        if (v && !st && ex) model_resv = {a[31:2], 2'b00};
    endtask

    task automatic cmp(input string tag, input string fld,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    // Monitor: pops one expected item per driven cycle, mid-low phase.
    always @(negedge clk) begin
        #(T/4);
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp(e.tag, "mem_addr",   mem_addr,         e.addr);
            cmp(e.tag, "mem_we",     32'(mem_we),      32'(e.we));
            cmp(e.tag, "size_bytes", 32'(size_bytes),  32'(e.bytes));
            cmp(e.tag, "rev_order",  32'(rev_order),   32'(e.rev));
            cmp(e.tag, "carry_we",   32'(carry_we),    32'(e.cwe));
            cmp(e.tag, "carry_val",  32'(carry_val),   32'(e.cval));
        end
    end

    bit finished = 1'b0;

    initial begin
        #(T * 200000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9: reset state, nothing strobed
        drv(0, 1, 0, EXB, 2, 32'h100, "R9 idle after reset");
        // R8: store before any exclusive load fails
        drv(1, 1, 0, EXB, 2, 32'h100, "R8 store before load");
        drv(1, 1, 0, EXB, 2, 32'hFFFF_FFFC, "R8 store to top word");
        // R1: size decode, plain unaligned access passes through (R3)
        for (int c = 0; c < 4; c++) drv(1, 0, 0, 32'h0, 2'(c), 32'h13, "R1 size code");
        // R4 / R3: exclusive load on unaligned address
        drv(1, 0, 0, EXB, 2, 32'h203, "R4 excl load");
        // R5: matching store through another byte offset
        drv(1, 1, 0, EXB, 2, 32'h201, "R5 excl store hit");
        // R6: repeat succeeds, reservation kept
        drv(1, 1, 0, EXB, 2, 32'h200, "R6 repeat store");
        drv(1, 1, 0, EXB, 2, 32'h204, "R5 excl store miss");
        // R7: plain traffic leaves reservation alone
        drv(1, 0, 0, 32'h0, 2, 32'h300, "R7 plain load");
        drv(1, 1, 0, 32'h0, 2, 32'h302, "R7 plain store");
        drv(1, 1, 0, EXB, 2, 32'h202, "R7 reservation kept");
        // R9: unstrobed exclusive load has no effect
        drv(0, 0, 0, EXB, 2, 32'h500, "R9 unstrobed load");
        drv(1, 1, 0, EXB, 2, 32'h200, "R9 reservation kept");
        // R2: immediate format ignores bits 9 and 10
        drv(1, 0, 1, EXB | RVB, 2, 32'h501, "R2 imm format load");
        drv(1, 1, 1, EXB | RVB, 1, 32'h503, "R2 imm format store");
        drv(1, 1, 0, EXB, 2, 32'h200, "R2 reservation kept");
        drv(1, 0, 0, RVB, 1, 32'h602, "R2 reversed plain");
        // R4: new exclusive load replaces reservation
        drv(1, 0, 0, EXB | RVB, 2, 32'h502, "R4 reload");
        drv(1, 1, 0, EXB, 2, 32'h203, "R4 old word now fails");
        drv(1, 1, 0, EXB, 2, 32'h503, "R4 new word hits");
        drv(0, 0, 0, 32'h0, 0, 32'h0, "R9 drain");
        @(negedge clk); @(negedge clk);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule